// File: doc/BRIEF.md
# UART Channel Host Register File

This block is the processor-facing register file of a single 16550-style UART channel. A host reaches it through a 3-bit address, a chip select, separate read and write strobes and an 8-bit write bus. Each access lasts one clock cycle. The block decodes the access and keeps the control registers: interrupt enable, FIFO control, line control, modem control, scratch, and the two bytes of the baud divisor. The rest of the UART reads these registers from output ports.

Accesses to the transmit and receive data locations are not stored here. A transmit write becomes a one-cycle push strobe that carries the byte. A receive read becomes a one-cycle pop strobe, and the block returns the byte that the data path presents. Interrupt status, line status and modem status are also supplied from outside and are only returned on reads.

A read and a write at the same address can reach different registers. While the top bit of the line control register is set, the two divisor bytes replace the data and interrupt-enable locations at addresses 0 and 1. Addresses 2 to 7 keep their usual mapping in both settings.

Top module: `uart_regbank`

## Requirements
- R1: After reset, rdata, rx_pop, tx_push and tx_data are 0, and the stored registers (interrupt enable, FIFO control, line control, modem control, scratch, divisor low, divisor high) are all 0.
- R2: With line-control bit 7 clear, addresses 1, 3, 4 and 7 are readable and writable storage for interrupt enable, line control, modem control and scratch. A written byte appears on ier_o, lcr_o and mcr_o at the next clock edge, and a later read of the same address returns it.
- R3: A write to address 2 loads the FIFO control register, which is visible on fcr_o. A read of address 2 returns isr_in.
- R4: A read of address 5 returns lsr_in and a read of address 6 returns msr_in. Writes to address 5 or 6 change no stored register and raise no strobe.
- R5: A read of address 0 with line-control bit 7 clear returns rhr_in as sampled at the read edge. It also raises rx_pop for exactly one cycle, in the same cycle that rdata updates.
- R6: A write of address 0 with line-control bit 7 clear raises tx_push for exactly one cycle after the write edge, with tx_data holding the written byte. It leaves every stored register unchanged.
- R7: With line-control bit 7 set, address 0 reads and writes the divisor low byte (dll_o) and address 1 reads and writes the divisor high byte (dlm_o). No strobe is raised, and the interrupt enable register is not touched.
- R8: With line-control bit 7 set, addresses 2 to 7 behave exactly as in R2, R3 and R4.
- R9: Read data is registered. rdata changes only in the cycle after a selected read and holds its value otherwise. With cs low, neither rd nor wr has any effect.
- R10: A cycle that asserts both rd and wr at the same address returns the value held before that write, and the write takes effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| rhr_in | input | 8 | Receive byte offered by the data path |
| isr_in | input | 8 | Interrupt status value |
| lsr_in | input | 8 | Line status value |
| msr_in | input | 8 | Modem status value |
| rx_pop | output | 1 | One-cycle pulse after a receive-data read |
| tx_push | output | 1 | One-cycle pulse after a transmit-data write |
| tx_data | output | 8 | Byte carried with tx_push |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |

## Verification
A decode error sends a write to the wrong register. The fault shows one cycle later on the wrong output port, or it shows as a missing or spurious strobe. A wrong divisor-access bit moves addresses 0 and 1 between the data strobes and the divisor bytes, so the next access to either address exposes it. A storage or read-mux fault shows on rdata one cycle after the first read of the affected address. The bench therefore writes every address with both settings of the divisor-access bit and reads all eight addresses back after each pass.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_IEN  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_LCTL = 3'd3;
  localparam logic [AW-1:0] A_MCTL = 3'd4;
  localparam logic [AW-1:0] A_LSTS = 3'd5;
  localparam logic [AW-1:0] A_MSTS = 3'd6;
  localparam logic [AW-1:0] A_SCR  = 3'd7;

  // index of each stored register in the storage array
  localparam int unsigned NREG   = 7;
  localparam int unsigned IX_IER = 0;
  localparam int unsigned IX_FCR = 1;
  localparam int unsigned IX_LCR = 2;
  localparam int unsigned IX_MCR = 3;
  localparam int unsigned IX_SPR = 4;
  localparam int unsigned IX_DLL = 5;
  localparam int unsigned IX_DLM = 6;

  typedef enum logic [3:0] {
    RS_NONE, RS_RHR, RS_IER, RS_ISR, RS_LCR, RS_MCR,
    RS_LSR, RS_MSR, RS_SPR, RS_DLL, RS_DLM
  } rd_sel_e;

  typedef struct packed {
    logic thr;
    logic [NREG-1:0] reg_we;
  } wr_dec_t;

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
(
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          dlab,
  output wr_dec_t       wdec,
  output rd_sel_e       rsel
);

  always_comb begin
    wdec = '0;
    if (cs && wr) begin
      case (addr)
        A_DATA: if (dlab) wdec.reg_we[IX_DLL] = 1'b1;
                else      wdec.thr            = 1'b1;
        A_IEN:  if (dlab) wdec.reg_we[IX_DLM] = 1'b1;
                else      wdec.reg_we[IX_IER] = 1'b1;
        A_STAT: wdec.reg_we[IX_FCR] = 1'b1;
        A_LCTL: wdec.reg_we[IX_LCR] = 1'b1;
        A_MCTL: wdec.reg_we[IX_MCR] = 1'b1;
        A_SCR:  wdec.reg_we[IX_SPR] = 1'b1;
        default: wdec = '0;
      endcase
    end
  end

  always_comb begin
    rsel = RS_NONE;
    if (cs && rd) begin
      case (addr)
        A_DATA: rsel = dlab ? RS_DLL : RS_RHR;
        A_IEN:  rsel = dlab ? RS_DLM : RS_IER;
        A_STAT: rsel = RS_ISR;
        A_LCTL: rsel = RS_LCR;
        A_MCTL: rsel = RS_MCR;
        A_LSTS: rsel = RS_LSR;
        A_MSTS: rsel = RS_MSR;
        A_SCR:  rsel = RS_SPR;
        default: rsel = RS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uart_regbank_store.sv
module uart_regbank_store
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       reg_we,
  input  logic [DW-1:0]         wdata,
  output logic [NREG-1:0][DW-1:0] regs
);

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] regs_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_comb begin
      regs_d[i] = regs_q[i];
      if (reg_we[i]) regs_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= regs_d[i];
    end
  end

  assign regs = regs_q;

endmodule

// File: rtl/uart_regbank_rdmux.sv
module uart_regbank_rdmux
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  rd_sel_e                 rsel,
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [DW-1:0]           rhr_in,
  input  logic [DW-1:0]           isr_in,
  input  logic [DW-1:0]           lsr_in,
  input  logic [DW-1:0]           msr_in,
  output logic [DW-1:0]           rdata
);

  logic [DW-1:0] mux_val;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;
  logic          rd_en;

  always_comb begin
    case (rsel)
      RS_RHR:  mux_val = rhr_in;
      RS_IER:  mux_val = regs[IX_IER];
      RS_ISR:  mux_val = isr_in;
      RS_LCR:  mux_val = regs[IX_LCR];
      RS_MCR:  mux_val = regs[IX_MCR];
      RS_LSR:  mux_val = lsr_in;
      RS_MSR:  mux_val = msr_in;
      RS_SPR:  mux_val = regs[IX_SPR];
      RS_DLL:  mux_val = regs[IX_DLL];
      RS_DLM:  mux_val = regs[IX_DLM];
      default: mux_val = '0;
    endcase
  end

  assign rd_en = (rsel != RS_NONE);

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = mux_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/uart_regbank_strobe.sv
module uart_regbank_strobe
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_sel_e       rsel,
  input  logic          thr_we,
  input  logic [DW-1:0] wdata,
  output logic          rx_pop,
  output logic          tx_push,
  output logic [DW-1:0] tx_data
);

  logic          pop_q, pop_d;
  logic          push_q, push_d;
  logic [DW-1:0] txd_q, txd_d;

  always_comb begin
    pop_d  = (rsel == RS_RHR);
    push_d = thr_we;
    txd_d  = txd_q;
    if (thr_we) txd_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_q  <= 1'b0;
      push_q <= 1'b0;
      txd_q  <= '0;
    end else begin
      pop_q  <= pop_d;
      push_q <= push_d;
      txd_q  <= txd_d;
    end
  end

  assign rx_pop  = pop_q;
  assign tx_push = push_q;
  assign tx_data = txd_q;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rhr_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  output logic          rx_pop,
  output logic          tx_push,
  output logic [DW-1:0] tx_data,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] fcr_o,
  output logic [DW-1:0] lcr_o,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] dll_o,
  output logic [DW-1:0] dlm_o
);

  localparam int unsigned DLAB_BIT = DW - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_int = rst_sync_q[1];

  wr_dec_t                 wdec;
  rd_sel_e                 rsel;
  logic [NREG-1:0][DW-1:0] regs;

  uart_regbank_decode u_dec (
    .cs   (cs),
    .rd   (rd),
    .wr   (wr),
    .addr (addr),
    .dlab (regs[IX_LCR][DLAB_BIT]),
    .wdec (wdec),
    .rsel (rsel)
  );

  uart_regbank_store #(.DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .reg_we (wdec.reg_we),
    .wdata  (wdata),
    .regs   (regs)
  );

  uart_regbank_rdmux #(.DW(DW)) u_rdmux (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .rsel   (rsel),
    .regs   (regs),
    .rhr_in (rhr_in),
    .isr_in (isr_in),
    .lsr_in (lsr_in),
    .msr_in (msr_in),
    .rdata  (rdata)
  );

  uart_regbank_strobe #(.DW(DW)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rsel    (rsel),
    .thr_we  (wdec.thr),
    .wdata   (wdata),
    .rx_pop  (rx_pop),
    .tx_push (tx_push),
    .tx_data (tx_data)
  );

  assign ier_o = regs[IX_IER];
  assign fcr_o = regs[IX_FCR];
  assign lcr_o = regs[IX_LCR];
  assign mcr_o = regs[IX_MCR];
  assign dll_o = regs[IX_DLL];
  assign dlm_o = regs[IX_DLM];

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [2:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] rhr_in,
  input logic [DW-1:0] lsr_in,
  input logic          rx_pop,
  input logic          tx_push,
  input logic [DW-1:0] tx_data,
  input logic [DW-1:0] ier_o,
  input logic [DW-1:0] lcr_o,
  input logic [DW-1:0] mcr_o,
  input logic [DW-1:0] dll_o
);

  logic dlab;
  assign dlab = lcr_o[DW-1];

  p_pop_after_rhr_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 3'd0 && !dlab) |=> (rx_pop && rdata == $past(rhr_in)));

  p_pop_only_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_pop) |-> $past(cs && rd && addr == 3'd0 && !dlab));

  p_push_carries_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd0 && !dlab) |=> (tx_push && tx_data == $past(wdata)));

  p_divisor_low_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd0 && dlab) |=> (dll_o == $past(wdata) && !tx_push));

  p_divisor_high_keeps_ier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd1 && dlab) |=> $stable(ier_o));

  p_status_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && (addr == 3'd5 || addr == 3'd6)) |=>
      ($stable(lcr_o) && $stable(ier_o) && $stable(mcr_o) && $stable(dll_o) && !tx_push));

  p_lsr_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 3'd5) |=> (rdata == $past(lsr_in)));

  p_rdata_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));

endmodule

bind uart_regbank uart_regbank_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs      (cs),
  .rd      (rd),
  .wr      (wr),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .rhr_in  (rhr_in),
  .lsr_in  (lsr_in),
  .rx_pop  (rx_pop),
  .tx_push (tx_push),
  .tx_data (tx_data),
  .ier_o   (ier_o),
  .lcr_o   (lcr_o),
  .mcr_o   (mcr_o),
  .dll_o   (dll_o)
);

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, rd, wr;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, rhr_in, isr_in, lsr_in, msr_in;
  logic       rx_pop, tx_push;
  logic [7:0] tx_data, ier_o, fcr_o, lcr_o, mcr_o, dll_o, dlm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_dll, m_dlm;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rhr_in(rhr_in), .isr_in(isr_in),
    .lsr_in(lsr_in), .msr_in(msr_in), .rx_pop(rx_pop), .tx_push(tx_push),
    .tx_data(tx_data), .ier_o(ier_o), .fcr_o(fcr_o), .lcr_o(lcr_o),
    .mcr_o(mcr_o), .dll_o(dll_o), .dlm_o(dlm_o)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] a, logic dl);
    case (a)
      3'd0: return dl ? "R7" : "R5";
      3'd1: return dl ? "R7" : "R2";
      3'd2: return dl ? "R8" : "R3";
      3'd5, 3'd6: return dl ? "R8" : "R4";
      default: return dl ? "R8" : "R2";
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [2:0] a);
    logic dl = m_lcr[7];
    case (a)
      3'd0: return dl ? m_dll : rhr_in;
      3'd1: return dl ? m_dlm : m_ier;
      3'd2: return isr_in;
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return lsr_in;
      3'd6: return msr_in;
      default: return m_spr;
    endcase
  endfunction

  task automatic check_ports(string tag);
    chk(tag, "ier_o", ier_o, m_ier);
    chk(tag, "fcr_o", fcr_o, m_fcr);
    chk(tag, "lcr_o", lcr_o, m_lcr);
    chk(tag, "mcr_o", mcr_o, m_mcr);
    chk(tag, "dll_o", dll_o, m_dll);
    chk(tag, "dlm_o", dlm_o, m_dlm);
  endtask

  // called at a negedge, returns at a negedge
  task automatic do_write(logic [2:0] a, logic [7:0] d);
    logic  dl = m_lcr[7];
    string t  = tag_of(a, dl);
    bit    push = (a == 3'd0) && !dl;
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    case (a)
      3'd0: if (dl) m_dll = d;
      3'd1: if (dl) m_dlm = d; else m_ier = d;
      3'd2: m_fcr = d;
      3'd3: m_lcr = d;
      3'd4: m_mcr = d;
      3'd7: m_spr = d;
      default: ;
    endcase
    check_ports(t);
    chk(push ? "R6" : t, "tx_push", {7'd0, tx_push}, {7'd0, push});
    if (push) chk("R6", "tx_data", tx_data, d);
    @(negedge clk);
    chk(push ? "R6" : t, "tx_push after one cycle", {7'd0, tx_push}, 8'd0);
  endtask

  task automatic do_read(logic [2:0] a);
    logic       dl  = m_lcr[7];
    string      t   = tag_of(a, dl);
    bit         pop = (a == 3'd0) && !dl;
    logic [7:0] e;
    rhr_in = 8'hA0 ^ {5'd0, a} ^ {checks[7:0]};
    e = exp_read(a);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    rhr_in = ~rhr_in;
    chk(t, "rdata", rdata, e);
    chk(pop ? "R5" : t, "rx_pop", {7'd0, rx_pop}, {7'd0, pop});
    @(negedge clk);
    chk(pop ? "R5" : t, "rx_pop after one cycle", {7'd0, rx_pop}, 8'd0);
    chk("R9", "rdata holds", rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    rhr_in = 8'h00; isr_in = 8'hC1; lsr_in = 8'h60; msr_in = 8'hB3;
    {m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_dll, m_dlm} = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_ports("R1");
    chk("R1", "rdata", rdata, 8'h00);
    chk("R1", "tx_data", tx_data, 8'h00);
    chk("R1", "strobes", {6'd0, rx_pop, tx_push}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(3'd7);   // R1: scratch reads 0 after reset

    // sweep: every address written and all read back, both divisor settings
    for (int pass = 0; pass < 2; pass++) begin
      for (int dl = 0; dl < 2; dl++) begin
        do_write(3'd3, {dl[0], 7'h03});
        for (int a = 0; a < 8; a++) begin
          logic [7:0] v = (8'h13 * (a + 1)) ^ {pass[0], 1'b0, dl[0], 5'd0};
          if (a == 3) v = {dl[0], v[6:0]};
          do_write(a[2:0], v);
        end
        for (int a = 0; a < 8; a++) do_read(a[2:0]);
        isr_in = isr_in + 8'h11; lsr_in = lsr_in ^ 8'h0F; msr_in = msr_in + 8'h05;
      end
    end

    // R9: rd/wr with cs low have no effect
    do_write(3'd3, 8'h03);
    do_read(3'd7);
    cs = 1'b0; rd = 1'b1; wr = 1'b1; addr = 3'd7; wdata = 8'hEE;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    chk("R9", "rdata with cs low", rdata, m_spr);
    chk("R9", "tx_push with cs low", {7'd0, tx_push}, 8'd0);
    do_read(3'd7);

    // R10: read and write together return the old value
    cs = 1'b1; rd = 1'b1; wr = 1'b1; addr = 3'd7; wdata = 8'h5C;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    chk("R10", "rdata on joint access", rdata, m_spr);
    m_spr = 8'h5C;
    @(negedge clk);
    do_read(3'd7);
    chk("R10", "scratch after joint access", rdata, 8'h5C);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule